// File: doc/BRIEF.md
# Legacy INTx Status and Mask Unit

This block gathers the four level-sensitive legacy interrupt wires of a bus segment (INTA, INTB, INTC, INTD) into sticky pending bits. Each wire has its own enable bit, and the block drives a single combined interrupt request upstream. The pending and enable bits sit at the top of one 32-bit control word. Every other bit of that word is ordinary storage, so software can keep unrelated settings there, and the block does not act on them.

Software reads the whole word combinationally on `rd_data`. It writes the word with per-byte lane enables. A one written to a pending bit acknowledges that line, and a zero written there leaves it alone. During initialisation, software writes `0xF000` to the upper halfword. That single write drops every pending bit and disables all four lines. The upstream sources are level-triggered, so a line that stays asserted keeps its pending bit set even after an acknowledge.

Top module: `intx_ctrl_unit`

## Requirements
- R1: When synchronous reset `rst_n` is low at a clock edge, the whole control word (pending bits, enable bits and storage) becomes zero and `irq_out` is low.
- R2: When line i of `irq_lines` (bit 0 = INTA up to bit 3 = INTD) is high at a clock edge, pending bit 28+i reads as one after that edge. It stays one after the line falls, until it is acknowledged.
- R3: A write with `wr_en` high and lane enable `wr_be[3]` high clears pending bit 28+i when `wr_data[28+i]` is one. Pending bits written with zero keep their value.
- R4: When the acknowledge of a pending bit lands on an edge where that line is still high, the bit remains set.
- R5: `irq_out` is high exactly when some line has both its pending bit (28+i) and its enable bit (22+i) set. A pending bit on a disabled line does not raise it.
- R6: Pending bits capture their lines whether or not the line is enabled. Setting the enable bit later raises `irq_out` for a line that is already pending.
- R7: Bits 27:0 are read/write storage. Byte lane k (`wr_be[k]`) updates bits 8k+7:8k. In lane 3 only bits 27:24 are storage. Lanes that are not enabled keep their bits.
- R8: A write can never set a pending bit. With its line low, a pending bit that is zero stays zero whatever is written.
- R9: Writing `0xF000_0000` with `wr_be = 4'b1100` clears all pending bits and all enable bits, and leaves bits 15:0 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_be | input | 4 | Byte lane enables for the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| irq_lines | input | 4 | Level interrupt lines, bit 0 = INTA |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The lines are driven in several patterns:
- A one-cycle pulse on a disabled line shows that capture does not depend on the enable, and that the bit is sticky.
- A line held high across an acknowledge separates a true level source from a lost event.
- A pending bit on a disabled line while other lines are enabled proves that masking works per line rather than globally.

Writes use mixed byte lanes and put ones on pending bits whose lines are idle. This separates write-one-to-clear from plain storage, and confirms that a write cannot create an interrupt. The initialisation halfword write is checked to clear pending and enable bits together without disturbing the low halfword.

// File: rtl/intx_pkg.sv
// Shared field positions of the INTx control word.
// Assumes a 32-bit word with pending bits above the enables.
package intx_pkg;
    localparam int REG_W    = 32;
    localparam int N_LINES  = 4;
    localparam int STAT_LSB = 28;
    localparam int EN_LSB   = 22;
    localparam int STORE_W  = STAT_LSB;
    localparam int N_LANES  = REG_W / 8;
endpackage

// File: rtl/intx_store.sv
// Byte-lane writable storage for the low bits of the control word.
// Assumes DW <= 8*LANES; bit b belongs to lane b/8.
module intx_store #(
    parameter int DW    = 28,
    parameter int LANES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LANES-1:0] wr_be,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    q
);
    // Store each bit whose lane is enabled; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            for (int b = 0; b < DW; b++) begin
                if (wr_be[b/8]) q[b] <= wr_data[b];
            end
        end
    end

    // R7
    lane0_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[0]) |=> (q[7:0] == $past(wr_data[7:0])));
    // R7
    lane1_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !wr_be[1]) |=> $stable(q[15:8]));
endmodule

// File: rtl/intx_status.sv
// Sticky per-line pending bits with write-one-to-clear.
// Assumes level lines synchronous to clk; a set from the line wins over a clear.
module intx_status #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines,
    input  logic [N-1:0] clr,
    output logic [N-1:0] stat
);
    for (genvar i = 0; i < N; i++) begin : g_line
        // Capture the line, otherwise hold unless acknowledged.
        always_ff @(posedge clk) begin
            if (!rst_n)        stat[i] <= 1'b0;
            else if (lines[i]) stat[i] <= 1'b1;
            else if (clr[i])   stat[i] <= 1'b0;
        end

        // R2
        capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lines[i] |=> stat[i]);
        // R3
        ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !lines[i]) |=> !stat[i]);
        // R8
        no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!stat[i] && !lines[i]) |=> !stat[i]);
    end
endmodule

// File: rtl/intx_merge.sv
// Masks pending bits with enables and ORs them into one request.
// Assumes an enable of one means the line may interrupt.
module intx_merge #(
    parameter int N = 4
) (
    input  logic [N-1:0] stat,
    input  logic [N-1:0] en,
    output logic         req
);
    logic [N:0] chain;
    assign chain[0] = 1'b0;
    for (genvar i = 0; i < N; i++) begin : g_or
        assign chain[i+1] = chain[i] | (stat[i] & en[i]);
    end
    assign req = chain[N];
endmodule

// File: rtl/intx_ctrl_unit.sv
// INTx control word: pending bits 31:28, enables 25:22, storage 27:0.
// Assumes synchronous active-low reset and a combinational read port.
module intx_ctrl_unit
    import intx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [N_LANES-1:0] wr_be,
    input  logic [REG_W-1:0]   wr_data,
    output logic [REG_W-1:0]   rd_data,
    input  logic [N_LINES-1:0] irq_lines,
    output logic               irq_out
);
    localparam int STAT_LANE = STAT_LSB / 8;

    logic [STORE_W-1:0] store_q;
    logic [N_LINES-1:0] stat;
    logic [N_LINES-1:0] clr;
    logic [N_LINES-1:0] en;

    // Acknowledge mask from a write covering the pending bits.
    assign clr = (wr_en && wr_be[STAT_LANE]) ? wr_data[STAT_LSB +: N_LINES] : '0;
    assign en  = store_q[EN_LSB +: N_LINES];

    intx_store #(.DW(STORE_W), .LANES(N_LANES)) i_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data[STORE_W-1:0]), .q(store_q)
    );

    intx_status #(.N(N_LINES)) i_status (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines), .clr(clr), .stat(stat)
    );

    intx_merge #(.N(N_LINES)) i_merge (
        .stat(stat), .en(en), .req(irq_out)
    );

    assign rd_data = {stat, store_q};

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));
    // R5
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[EN_LSB +: N_LINES] == '0) |-> !irq_out);
endmodule

// File: tb/test_intx_ctrl_unit.sv
module test_intx_ctrl_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_be = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [3:0]  irq_lines = '0;
    logic        irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] q_rd[$];
    logic        q_irq[$];
    string       q_tag[$];

    always #2 clk = ~clk;

    intx_ctrl_unit i_intx_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_be(wr_be),
        .wr_data(wr_data), .rd_data(rd_data), .irq_lines(irq_lines),
        .irq_out(irq_out)
    );

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wr(input logic [31:0] d, input logic [3:0] be);
        wr_en = 1'b1; wr_data = d; wr_be = be;
        step();
        wr_en = 1'b0; wr_data = '0; wr_be = '0;
    endtask

    task automatic pulse(input logic [3:0] l);
        irq_lines = l;
        step();
        irq_lines = '0;
    endtask

    task automatic expect_st(input string tag, input logic [31:0] rd, input logic irq);
        q_rd.push_back(rd); q_irq.push_back(irq); q_tag.push_back(tag);
    endtask

    // Monitor: compare queued expectations at the falling edge
    always @(negedge clk) begin
        if (q_tag.size() > 0) begin
            logic [31:0] e_rd;
            logic        e_irq;
            string       t;
            e_rd = q_rd.pop_front(); e_irq = q_irq.pop_front(); t = q_tag.pop_front();
            checks++;
            if (rd_data !== e_rd || irq_out !== e_irq) begin
                errors++;
                $display("FAIL %s: rd_data=%h irq_out=%b expected rd_data=%h irq_out=%b",
                         t, rd_data, irq_out, e_rd, e_irq);
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        irq_lines = 4'b1111;
        step(); step();
        irq_lines = '0;
        step();
        rst_n = 1'b1;
        expect_st("R1 reset", 32'h0, 1'b0);
        // R7: lane writes
        wr(32'hFF12_3456, 4'b0111);
        expect_st("R7 three lanes", 32'h0012_3456, 1'b0);
        wr(32'hFFFF_FFFF, 4'b0001);
        expect_st("R7 lane0 only", 32'h0012_34FF, 1'b0);
        // R6 / R2: capture on a disabled line, sticky
        pulse(4'b0010);
        expect_st("R6 capture while masked", 32'h2012_34FF, 1'b0);
        step();
        expect_st("R2 sticky", 32'h2012_34FF, 1'b0);
        // R6 / R5: enable INTB (bit 23)
        wr(32'h0092_0000, 4'b0100);
        expect_st("R6 late enable", 32'h2092_34FF, 1'b1);
        // R8 / R3: ones on idle pending bits, zero on INTB
        wr(32'hC000_0000, 4'b1000);
        expect_st("R8 no set, R3 zero keeps", 32'h2092_34FF, 1'b1);
        // R3: acknowledge INTB
        wr(32'h2000_0000, 4'b1000);
        expect_st("R3 ack clears", 32'h0092_34FF, 1'b0);
        // R4: held INTA survives acknowledge
        irq_lines = 4'b0001;
        step();
        expect_st("R2 held line", 32'h1092_34FF, 1'b0);
        wr(32'h00D2_0000, 4'b0100);
        expect_st("R5 enable INTA", 32'h10D2_34FF, 1'b1);
        wr(32'h1000_0000, 4'b1000);
        expect_st("R4 ack while active", 32'h10D2_34FF, 1'b1);
        irq_lines = '0;
        step();
        expect_st("R2 after line drops", 32'h10D2_34FF, 1'b1);
        wr(32'h1000_0000, 4'b1000);
        expect_st("R3 ack after drop", 32'h00D2_34FF, 1'b0);
        // R5: pending on a disabled line with others enabled
        pulse(4'b1000);
        expect_st("R5 INTD masked", 32'h80D2_34FF, 1'b0);
        // R9: init halfword write
        wr(32'hF000_0000, 4'b1100);
        expect_st("R9 init", 32'h0000_34FF, 1'b0);
        // R7: top lane storage bits 27:24
        wr(32'h0C00_0000, 4'b1000);
        expect_st("R7 lane3 storage", 32'h0C00_34FF, 1'b0);
        step(); step();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule